// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block collects the event pulses of a packet network controller into an eight-bit status register and combines them with an enable mask to drive a single interrupt line toward the host. Each status bit stays set until the host writes a one to it, so no event is lost between the time the interrupt is raised and the time it is serviced. The top bit reports that the controller is halted. It is set on every cycle the halt input is high, and it has no enable bit.

Three saturating eight-bit error tallies sit beside the status register. They count framing-alignment faults, checksum faults and frames dropped for lack of buffer space. Reading a tally returns its value and clears it. When a tally crosses into its upper half it raises the counter-overflow status bit, so software can drain the tallies before they saturate. The host reaches all registers through a simple synchronous read/write strobe bus with registered read data.

Top module: `irq_status_unit`

## Requirements
- R1: The status register is at address 0. Its bit positions are: 0 frame received, 1 frame sent, 2 receive fault, 3 send fault, 4 ring overwrite warning, 5 counter overflow, 6 buffer transfer done, 7 halted. A pulse on the matching event input sets its bit at the next clock edge.
- R2: A write to address 0 clears each status bit whose write-data bit is 1 and leaves bits written with 0 unchanged. Writing 0xFF clears every bit that has no concurrent set source.
- R3: The mask register is at address 1. Bits 0 to 6 are read/write enables in the same positions as the status bits. Bit 7 always reads 0.
- R4: `irq` is high when status bit 7 is set, or when any status bit 0 to 6 is set together with its mask bit. It changes at the same clock edge as the status or mask change that causes it.
- R5: Status bit 7 is set at every edge at which `ctl_halted` is high. A write-1 clear has no effect on it while the halt input stays high, and no mask bit can suppress it.
- R6: The alignment, checksum and dropped-frame tallies are read at addresses 2, 3 and 4. Each counts its increment pulses and holds at 0xFF.
- R7: A read of a tally returns its value before the read and clears it. An increment in the same cycle as that read leaves the tally at 1.
- R8: Status bit 5 is set at the edge at which any tally moves from a value below 0x80 to a value of 0x80 or more.
- R9: If a status bit's set source is active in the same cycle as a write-1 clear of that bit, the bit stays set.
- R10: Writing the mask as 0 drops `irq` when bit 7 is clear, and it leaves every status bit as it was.
- R11: Synchronous reset clears the status register, the mask, all tallies, `irq` and `reg_rdata`.
- R12: `reg_rdata` is loaded at the edge that samples `reg_rd` and holds its value until the next read. Addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| evt_rx_done | input | 1 | Frame received pulse |
| evt_tx_done | input | 1 | Frame sent pulse |
| evt_rx_fault | input | 1 | Receive fault pulse |
| evt_tx_fault | input | 1 | Send fault pulse |
| evt_ring_full | input | 1 | Receive ring overwrite warning pulse |
| evt_xfer_done | input | 1 | Buffer transfer complete pulse |
| ctl_halted | input | 1 | Level, high while the controller is halted |
| cnt_align_inc | input | 1 | Alignment fault tally increment |
| cnt_crc_inc | input | 1 | Checksum fault tally increment |
| cnt_miss_inc | input | 1 | Dropped frame tally increment |
| irq | output | 1 | Interrupt request |

## Verification
Status, mask, tallies and `irq` all update at the first rising edge that samples an event, strobe or halt level, so each result is due one edge after its stimulus. Read data is loaded at that same edge and is visible until the next read. The bench applies every stimulus at a falling edge and compares `irq` and `reg_rdata` with a behavioural model at the following falling edge, one full edge later. Directed reads check the exact values each requirement calls for, including the cycles in which a set and a clear, or a read and an increment, coincide.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int STAT_W = 8;

  localparam int BIT_RX_DONE  = 0;
  localparam int BIT_TX_DONE  = 1;
  localparam int BIT_RX_FAULT = 2;
  localparam int BIT_TX_FAULT = 3;
  localparam int BIT_RING     = 4;
  localparam int BIT_CNT_OVF  = 5;
  localparam int BIT_XFER     = 6;
  localparam int BIT_HALT     = 7;

  localparam int ADR_STATUS     = 0;
  localparam int ADR_MASK       = 1;
  localparam int ADR_TALLY_BASE = 2;

  localparam int NUM_TALLY = 3;
  localparam int TAL_ALIGN = 0;
  localparam int TAL_CRC   = 1;
  localparam int TAL_MISS  = 2;
endpackage

// File: rtl/irq_status_bits.sv
module irq_status_bits #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] st_q,
  output logic [W-1:0] st_d
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    // a set source outranks a same-cycle clear
    assign st_d[i] = set_vec[i] | (st_q[i] & ~clr_vec[i]);

    always_ff @(posedge clk) begin
      if (rst) st_q[i] <= 1'b0;
      else     st_q[i] <= st_d[i];
    end
  end
endmodule

// File: rtl/irq_tally.sv
module irq_tally #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] value,
  output logic         crossed
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] base;
  logic [W-1:0] nxt;

  always_comb begin
    base = clr ? '0 : value;
    if (inc && base != TOP) nxt = base + 1'b1;
    else                    nxt = base;
  end

  // upper-half entry flags the overflow event once per crossing
  assign crossed = ~value[W-1] & nxt[W-1];

  always_ff @(posedge clk) begin
    if (rst) value <= '0;
    else     value <= nxt;
  end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int TALLY_W = 8
) (
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [STAT_W-1:0]                 status,
  input  logic [STAT_W-2:0]                 mask,
  input  logic [NUM_TALLY-1:0][TALLY_W-1:0] tally,
  output logic [STAT_W-1:0]                 data
);
  always_comb begin
    data = '0;
    if (addr == ADDR_W'(ADR_STATUS)) data = status;
    if (addr == ADDR_W'(ADR_MASK))   data = {1'b0, mask};
    for (int t = 0; t < NUM_TALLY; t++) begin
      if (addr == ADDR_W'(ADR_TALLY_BASE + t)) data = STAT_W'(tally[t]);
    end
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int TALLY_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              evt_rx_done,
  input  logic              evt_tx_done,
  input  logic              evt_rx_fault,
  input  logic              evt_tx_fault,
  input  logic              evt_ring_full,
  input  logic              evt_xfer_done,
  input  logic              ctl_halted,
  input  logic              cnt_align_inc,
  input  logic              cnt_crc_inc,
  input  logic              cnt_miss_inc,
  output logic              irq
);
  localparam int MASK_W = STAT_W - 1;

  logic [STAT_W-1:0]                 set_vec;
  logic [STAT_W-1:0]                 clr_vec;
  logic [STAT_W-1:0]                 st_q;
  logic [STAT_W-1:0]                 st_d;
  logic [MASK_W-1:0]                 mask_q;
  logic [MASK_W-1:0]                 mask_d;
  logic [NUM_TALLY-1:0]              tal_inc;
  logic [NUM_TALLY-1:0]              tal_clr;
  logic [NUM_TALLY-1:0]              tal_cross;
  logic [NUM_TALLY-1:0][TALLY_W-1:0] tally_q;
  logic [STAT_W-1:0]                 rd_mux;

  assign tal_inc[TAL_ALIGN] = cnt_align_inc;
  assign tal_inc[TAL_CRC]   = cnt_crc_inc;
  assign tal_inc[TAL_MISS]  = cnt_miss_inc;

  for (genvar t = 0; t < NUM_TALLY; t++) begin : g_tally
    assign tal_clr[t] = reg_rd && (reg_addr == ADDR_W'(ADR_TALLY_BASE + t));

    irq_tally #(.W(TALLY_W)) u_tally (
      .clk     (clk),
      .rst     (rst),
      .inc     (tal_inc[t]),
      .clr     (tal_clr[t]),
      .value   (tally_q[t]),
      .crossed (tal_cross[t])
    );
  end

  always_comb begin
    set_vec               = '0;
    set_vec[BIT_RX_DONE]  = evt_rx_done;
    set_vec[BIT_TX_DONE]  = evt_tx_done;
    set_vec[BIT_RX_FAULT] = evt_rx_fault;
    set_vec[BIT_TX_FAULT] = evt_tx_fault;
    set_vec[BIT_RING]     = evt_ring_full;
    set_vec[BIT_CNT_OVF]  = |tal_cross;
    set_vec[BIT_XFER]     = evt_xfer_done;
    set_vec[BIT_HALT]     = ctl_halted;
  end

  assign clr_vec = (reg_wr && reg_addr == ADDR_W'(ADR_STATUS)) ? reg_wdata : '0;

  irq_status_bits #(.W(STAT_W)) u_status (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .st_q    (st_q),
    .st_d    (st_d)
  );

  assign mask_d = (reg_wr && reg_addr == ADDR_W'(ADR_MASK)) ? reg_wdata[MASK_W-1:0] : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      mask_q <= mask_d;
      irq    <= |(st_d & {1'b1, mask_d});
    end
  end

  irq_read_mux #(.ADDR_W(ADDR_W), .TALLY_W(TALLY_W)) u_rmux (
    .addr   (reg_addr),
    .status (st_q),
    .mask   (mask_q),
    .tally  (tally_q),
    .data   (rd_mux)
  );

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk
  import irq_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int TALLY_W = 8
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              reg_wr,
  input logic                              reg_rd,
  input logic [ADDR_W-1:0]                 reg_addr,
  input logic [7:0]                        reg_wdata,
  input logic                              evt_rx_done,
  input logic                              ctl_halted,
  input logic                              cnt_align_inc,
  input logic                              cnt_crc_inc,
  input logic [STAT_W-1:0]                 st_q,
  input logic [STAT_W-2:0]                 mask_q,
  input logic [NUM_TALLY-1:0][TALLY_W-1:0] tally_q,
  input logic                              irq
);
  localparam logic [TALLY_W-1:0] T_TOP  = {TALLY_W{1'b1}};
  localparam logic [TALLY_W-1:0] T_HALF = {1'b0, {(TALLY_W-1){1'b1}}};

  logic wr_stat, rd_align, rd_crc;
  assign wr_stat  = reg_wr && reg_addr == ADDR_W'(ADR_STATUS);
  assign rd_align = reg_rd && reg_addr == ADDR_W'(ADR_TALLY_BASE + TAL_ALIGN);
  assign rd_crc   = reg_rd && reg_addr == ADDR_W'(ADR_TALLY_BASE + TAL_CRC);

  assert_halt_sets_R5: assert property (@(posedge clk) disable iff (rst)
    ctl_halted |=> st_q[BIT_HALT]);

  assert_irq_level_R4: assert property (@(posedge clk) disable iff (rst)
    irq == (|(st_q & {1'b1, mask_q})));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    evt_rx_done |=> st_q[BIT_RX_DONE]);

  assert_w1c_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && reg_wdata[BIT_RX_DONE] && !evt_rx_done) |=> !st_q[BIT_RX_DONE]);

  assert_saturate_R6: assert property (@(posedge clk) disable iff (rst)
    (tally_q[TAL_ALIGN] == T_TOP && !rd_align) |=> tally_q[TAL_ALIGN] == T_TOP);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_align && !cnt_align_inc) |=> tally_q[TAL_ALIGN] == '0);

  assert_cross_flags_R8: assert property (@(posedge clk) disable iff (rst)
    (tally_q[TAL_CRC] == T_HALF && cnt_crc_inc && !rd_crc) |=> st_q[BIT_CNT_OVF]);
endmodule

bind irq_status_unit irq_status_unit_chk #(.ADDR_W(ADDR_W), .TALLY_W(TALLY_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .reg_wr        (reg_wr),
  .reg_rd        (reg_rd),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .evt_rx_done   (evt_rx_done),
  .ctl_halted    (ctl_halted),
  .cnt_align_inc (cnt_align_inc),
  .cnt_crc_inc   (cnt_crc_inc),
  .st_q          (st_q),
  .mask_q        (mask_q),
  .tally_q       (tally_q),
  .irq           (irq)
);

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic evt_rx_done = 0, evt_tx_done = 0, evt_rx_fault = 0, evt_tx_fault = 0;
  logic evt_ring_full = 0, evt_xfer_done = 0, ctl_halted = 0;
  logic cnt_align_inc = 0, cnt_crc_inc = 0, cnt_miss_inc = 0;
  logic irq;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_status_unit uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_rx_done(evt_rx_done), .evt_tx_done(evt_tx_done), .evt_rx_fault(evt_rx_fault),
    .evt_tx_fault(evt_tx_fault), .evt_ring_full(evt_ring_full), .evt_xfer_done(evt_xfer_done),
    .ctl_halted(ctl_halted), .cnt_align_inc(cnt_align_inc), .cnt_crc_inc(cnt_crc_inc),
    .cnt_miss_inc(cnt_miss_inc), .irq(irq)
  );

  // behavioural reference model
  int m_st, m_mask, m_irq, m_rdata, m_set, m_clr, a;
  int m_tal[3];
  int n_tal[3];
  int m_inc[3];
  string m_rtag = "R11";

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_mask = 0; m_irq = 0; m_rdata = 0; m_rtag = "R11";
      for (int t = 0; t < 3; t++) m_tal[t] = 0;
    end else begin
      a = int'(reg_addr);
      m_inc[0] = int'(cnt_align_inc); m_inc[1] = int'(cnt_crc_inc); m_inc[2] = int'(cnt_miss_inc);
      if (reg_rd) begin
        if (a == 0)      begin m_rdata = m_st;        m_rtag = "R1";  end
        else if (a == 1) begin m_rdata = m_mask;      m_rtag = "R3";  end
        else if (a <= 4) begin m_rdata = m_tal[a-2];  m_rtag = "R6";  end
        else             begin m_rdata = 0;           m_rtag = "R12"; end
      end
      m_set = int'(evt_rx_done) | (int'(evt_tx_done) << 1) | (int'(evt_rx_fault) << 2) |
              (int'(evt_tx_fault) << 3) | (int'(evt_ring_full) << 4) |
              (int'(evt_xfer_done) << 6) | (int'(ctl_halted) << 7);
      for (int t = 0; t < 3; t++) begin
        n_tal[t] = (reg_rd && a == t + 2) ? 0 : m_tal[t];
        if (m_inc[t] != 0 && n_tal[t] < 255) n_tal[t] = n_tal[t] + 1;
        if (m_tal[t] < 128 && n_tal[t] >= 128) m_set = m_set | 32;
        m_tal[t] = n_tal[t];
      end
      m_clr = (reg_wr && a == 0) ? int'(reg_wdata) : 0;
      m_st  = (m_set | (m_st & ~m_clr)) & 255;
      if (reg_wr && a == 1) m_mask = int'(reg_wdata) & 127;
      m_irq = ((m_st & (m_mask | 128)) != 0) ? 1 : 0;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check("R4 (model irq)", int'(irq), m_irq);
    check({m_rtag, " (model rdata)"}, int'(reg_rdata), m_rdata);
    reg_wr = 0; reg_rd = 0;
    evt_rx_done = 0; evt_tx_done = 0; evt_rx_fault = 0; evt_tx_fault = 0;
    evt_ring_full = 0; evt_xfer_done = 0;
    cnt_align_inc = 0; cnt_crc_inc = 0; cnt_miss_inc = 0;
  endtask

  task automatic wr_reg(int ad, int d);
    reg_wr = 1; reg_addr = 3'(ad); reg_wdata = 8'(d);
    tick();
  endtask

  task automatic rd_reg(int ad, int exp, string tag);
    reg_rd = 1; reg_addr = 3'(ad);
    tick();
    check(tag, int'(reg_rdata), exp);
  endtask

  task automatic pulse(int idx);
    case (idx)
      0: evt_rx_done = 1;
      1: evt_tx_done = 1;
      2: evt_rx_fault = 1;
      3: evt_tx_fault = 1;
      4: evt_ring_full = 1;
      6: evt_xfer_done = 1;
      default: ;
    endcase
    tick();
  endtask

  task automatic bump(int which, int n);
    for (int k = 0; k < n; k++) begin
      if (which == 0) cnt_align_inc = 1;
      else if (which == 1) cnt_crc_inc = 1;
      else cnt_miss_inc = 1;
      tick();
    end
  endtask

  initial begin
    repeat (3) tick();
    check("R11 irq in reset", int'(irq), 0);
    rst = 0;
    rd_reg(0, 8'h00, "R11 status after reset");
    rd_reg(1, 8'h00, "R11 mask after reset");
    rd_reg(2, 8'h00, "R11 tally after reset");

    // R1: each event lands in its own bit
    for (int i = 0; i < 7; i++) begin
      if (i == 5) continue;
      pulse(i);
      rd_reg(0, 1 << i, "R1 event bit position");
      wr_reg(0, 8'hFF);
    end
    rd_reg(0, 8'h00, "R2 all clear after 0xFF");

    // R2: partial write-1-clear
    pulse(0); pulse(1); pulse(3); pulse(6);
    wr_reg(0, 8'h0A);
    rd_reg(0, 8'h41, "R2 selective clear");
    wr_reg(0, 8'h00);
    rd_reg(0, 8'h41, "R2 zero write keeps bits");
    wr_reg(0, 8'hFF);

    // R3: mask register
    wr_reg(1, 8'hFF);
    rd_reg(1, 8'h7F, "R3 mask bit7 reads 0");

    // R4: only unmasked bits raise irq
    wr_reg(1, 8'h02);
    pulse(0);
    check("R4 masked bit no irq", int'(irq), 0);
    pulse(1);
    check("R4 unmasked bit raises irq", int'(irq), 1);

    // R10: zero mask drops irq, keeps status
    wr_reg(1, 8'h00);
    check("R10 irq dropped", int'(irq), 0);
    rd_reg(0, 8'h03, "R10 status kept");
    wr_reg(0, 8'hFF);

    // R5: halt bit
    ctl_halted = 1;
    tick();
    check("R5 halt bit unmaskable irq", int'(irq), 1);
    wr_reg(0, 8'h80);
    rd_reg(0, 8'h80, "R5 halt bit survives clear while halted");
    ctl_halted = 0;
    wr_reg(0, 8'h80);
    rd_reg(0, 8'h00, "R5 halt bit clears after release");
    check("R5 irq low after release", int'(irq), 0);

    // R9: set wins over clear
    wr_reg(1, 8'h01);
    evt_rx_done = 1; reg_wr = 1; reg_addr = 3'd0; reg_wdata = 8'h01;
    tick();
    check("R9 irq kept by set", int'(irq), 1);
    rd_reg(0, 8'h01, "R9 bit kept by set");
    wr_reg(0, 8'hFF);

    // R6 / R7: tally count and clear on read
    bump(0, 5);
    rd_reg(2, 5, "R6 alignment count");
    rd_reg(2, 0, "R7 cleared by read");

    // R8: crossing into upper half
    bump(1, 127);
    rd_reg(0, 8'h00, "R8 no flag below 0x80");
    bump(1, 1);
    rd_reg(0, 8'h20, "R8 flag at 0x80");
    rd_reg(3, 8'h80, "R6 checksum count");
    wr_reg(0, 8'hFF);

    // R6: saturation
    bump(2, 300);
    rd_reg(4, 8'hFF, "R6 saturates at 0xFF");
    wr_reg(0, 8'hFF);

    // R7: read with concurrent increment
    bump(2, 3);
    reg_rd = 1; reg_addr = 3'd4; cnt_miss_inc = 1;
    tick();
    check("R7 read returns old value", int'(reg_rdata), 3);
    rd_reg(4, 1, "R7 concurrent increment kept");

    // R12: unused address and hold
    rd_reg(6, 0, "R12 unused address");
    rd_reg(1, 8'h01, "R3 mask readback");
    tick(); tick();
    check("R12 rdata holds", int'(reg_rdata), 8'h01);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R11 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule